// File: doc/BRIEF.md
# Audio Coprocessor Interval Timer Unit

This block gives a small 8-bit audio processor three interval timers. It shares its clock with the processor. A clock enable marks the processor's 1.024 MHz instruction rate. A shared prescaler divides that enable into two base ticks:

- a slow tick at 8 kHz, which drives timers 0 and 1;
- a fast tick at 64 kHz, which drives timer 2.

Each timer holds an 8-bit divisor. It advances a 4-bit output counter once every divisor-plus-one base ticks. Sound driver software uses these counters to pace its tempo.

Software reaches the unit through a plain register bus with address, write data, write strobe, read strobe and read data. It writes a control register to start or stop each timer and writes the divisors. It polls the output counters, and a poll empties the counter it reads. Reads are combinational: the addressed counter appears on the read data at once, and the clear takes effect at the clock edge that ends the read strobe.

Top module: `tmr_unit`

## Requirements
- R1: After reset every timer is stopped, every divisor is 0 and every output counter reads 0. With no timer enabled, the counters stay at 0.
- R2: The fast base tick occurs once every 16 clock-enable pulses. The slow base tick occurs once every 128 clock-enable pulses. Neither tick occurs on a cycle with `cpu_ce` low.
- R3: With divisor d, timers 0 and 1 increment their output counter exactly once every 128*(d+1) clock-enable pulses, for d from 0 to 255.
- R4: With divisor d, timer 2 increments its output counter exactly once every 16*(d+1) clock-enable pulses, for d from 0 to 255.
- R5: A read at 0xFD, 0xFE or 0xFF returns the output counter of timer 0, 1 or 2 in data bits [3:0], with bits [7:4] at 0. That read sets the counter to 0 at the end of the read cycle.
- R6: When a counter read and an increment of the same timer fall in the same cycle, the read returns the old value and the counter holds 1 afterwards.
- R7: The output counters are 4 bits wide and step from 15 to 0.
- R8: Bits 0, 1 and 2 of the control register at 0xF1 enable timers 0, 1 and 2. A timer whose bit is 0 neither advances its stage nor its output counter, and it keeps both values.
- R9: A control write that changes a timer's enable bit from 0 to 1 clears that timer's stage count and output counter. The next increment then comes a full d+1 base ticks later.
- R10: Divisors are written at 0xFA, 0xFB and 0xFC for timers 0, 1 and 2. Reads at any address other than 0xFD to 0xFF, including the divisor and control addresses, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_ce | input | 1 | Clock enable at the processor rate |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data for the current address |

## Verification
The hardest situations to reach are those where a timer's internal stage count matters, and that count is never visible at the ports.

The bench first aligns itself to timer 2's tick phase. It polls the counter every cycle until an increment appears, which fixes the tick edges to a known cycle. It then stops polling and places events on chosen cycles relative to those edges:

- a counter read in the exact cycle of an increment;
- a disable in the middle of an interval;
- a re-enable between ticks.

From these it predicts the cycle of the next increment. That prediction differs by whole base ticks depending on whether the stage count was kept or cleared. Wrap-around is reached the same way, by letting seventeen ticks pass unread.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    localparam int NUM_TMR    = 3;
    localparam int IDX_W      = $clog2(NUM_TMR);
    localparam int DIV_W      = 8;
    localparam int CNT_W      = 4;
    localparam int BUS_AW     = 8;
    localparam int BUS_DW     = 8;
    localparam int FAST_RATIO = 16;
    localparam int SLOW_RATIO = 128;
    localparam int FAST_IDX   = 2;

    localparam logic [BUS_AW-1:0] ADDR_CTRL     = 8'hF1;
    localparam logic [BUS_AW-1:0] ADDR_DIV0     = 8'hFA;
    localparam logic [BUS_AW-1:0] ADDR_DIV_LAST = ADDR_DIV0 + BUS_AW'(NUM_TMR - 1);
    localparam logic [BUS_AW-1:0] ADDR_OUT0     = 8'hFD;
    localparam logic [BUS_AW-1:0] ADDR_OUT_LAST = ADDR_OUT0 + BUS_AW'(NUM_TMR - 1);

    typedef enum logic [1:0] {SEL_NONE, SEL_CTRL, SEL_DIV, SEL_OUT} reg_sel_e;
    typedef enum logic {BASE_SLOW, BASE_FAST} base_e;

    typedef struct packed {
        reg_sel_e         sel;
        logic [IDX_W-1:0] idx;
    } reg_hit_t;

    typedef struct packed {
        logic [DIV_W-1:0] stage;
        logic [CNT_W-1:0] count;
    } tmr_state_t;

    function automatic base_e base_of(int idx);
        return (idx == FAST_IDX) ? BASE_FAST : BASE_SLOW;
    endfunction

    function automatic reg_hit_t decode(logic [BUS_AW-1:0] a);
        reg_hit_t h;
        h.sel = SEL_NONE;
        h.idx = '0;
        if (a == ADDR_CTRL) begin
            h.sel = SEL_CTRL;
        end else if (a >= ADDR_DIV0 && a <= ADDR_DIV_LAST) begin
            h.sel = SEL_DIV;
            h.idx = IDX_W'(a - ADDR_DIV0);
        end else if (a >= ADDR_OUT0 && a <= ADDR_OUT_LAST) begin
            h.sel = SEL_OUT;
            h.idx = IDX_W'(a - ADDR_OUT0);
        end
        return h;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
// Shared free-running divider of the clock enable. Both ratios are powers
// of two and the fast ratio divides the slow one, so every slow tick is
// also a fast tick.
module tmr_prescaler #(
    parameter int FAST = 16,
    parameter int SLOW = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic ce,
    output logic tick_fast,
    output logic tick_slow
);
    localparam int PW = $clog2(SLOW);
    localparam int FW = $clog2(FAST);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)     phase <= '0;
        else if (ce) phase <= phase + 1'b1;
    end

    assign tick_fast = ce && (phase[FW-1:0] == '1);
    assign tick_slow = ce && (phase == '1);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
// One interval timer: a stage counter that compares against the divisor
// and an output counter that a bus read empties.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_tick,
    input  logic             run,
    input  logic             restart,
    input  logic             rd_clr,
    input  logic [DIV_W-1:0] divisor,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    tmr_state_t st;

    assign fire  = run && base_tick && (st.stage == divisor);
    assign count = st.count;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            st <= '0;
        end else begin
            if (run && base_tick)
                st.stage <= fire ? '0 : st.stage + 1'b1;
            if (rd_clr)
                st.count <= fire ? CNT_W'(1) : '0;
            else if (fire)
                st.count <= st.count + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_unit.sv
`timescale 1ns/1ps
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int FAST_RATIO_P = FAST_RATIO,
    parameter int SLOW_RATIO_P = SLOW_RATIO
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_ce,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BUS_DW-1:0] bus_rdata
);
    reg_hit_t                         hit;
    logic                             wr_ctrl;
    logic                             tick_fast;
    logic                             tick_slow;
    logic [NUM_TMR-1:0]               run_q;
    logic [NUM_TMR-1:0]               fire_w;
    logic [NUM_TMR-1:0][CNT_W-1:0]    cnt_all;

    assign hit     = decode(bus_addr);
    assign wr_ctrl = bus_we && (hit.sel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst)          run_q <= '0;
        else if (wr_ctrl) run_q <= bus_wdata[NUM_TMR-1:0];
    end

    tmr_prescaler #(
        .FAST (FAST_RATIO_P),
        .SLOW (SLOW_RATIO_P)
    ) i_prescaler (
        .clk       (clk),
        .rst       (rst),
        .ce        (cpu_ce),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic [DIV_W-1:0] div_q;
        logic             base_w;
        logic             restart_w;
        logic             rd_clr_w;

        always_ff @(posedge clk) begin
            if (rst)
                div_q <= '0;
            else if (bus_we && hit.sel == SEL_DIV && hit.idx == IDX_W'(i))
                div_q <= bus_wdata[DIV_W-1:0];
        end

        if (base_of(i) == BASE_FAST) begin : g_fast
            assign base_w = tick_fast;
        end else begin : g_slow
            assign base_w = tick_slow;
        end

        assign restart_w = wr_ctrl && bus_wdata[i] && !run_q[i];
        assign rd_clr_w  = bus_re && (hit.sel == SEL_OUT) && (hit.idx == IDX_W'(i));

        tmr_channel i_channel (
            .clk       (clk),
            .rst       (rst),
            .base_tick (base_w),
            .run       (run_q[i]),
            .restart   (restart_w),
            .rd_clr    (rd_clr_w),
            .divisor   (div_q),
            .count     (cnt_all[i]),
            .fire      (fire_w[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (hit.sel == SEL_OUT)
            bus_rdata = BUS_DW'(cnt_all[hit.idx]);
    end
endmodule

// File: rtl/tmr_unit_chk.sv
`timescale 1ns/1ps
module tmr_unit_chk
    import tmr_pkg::*;
(
    input logic                          clk,
    input logic                          rst,
    input logic                          cpu_ce,
    input logic [BUS_AW-1:0]             bus_addr,
    input logic                          bus_re,
    input logic [NUM_TMR-1:0]            run_q,
    input logic [NUM_TMR-1:0]            fire_w,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all,
    input logic                          tick_fast,
    input logic                          tick_slow
);
    AST_FAST_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        tick_fast |-> cpu_ce); // R2
    AST_SLOW_ON_FAST: assert property (@(posedge clk) disable iff (rst)
        tick_slow |-> tick_fast); // R2

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
        logic rd_g;
        assign rd_g = bus_re && (bus_addr == ADDR_OUT0 + BUS_AW'(g));

        AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (rd_g && !fire_w[g]) |=> (cnt_all[g] == '0)); // R5
        AST_READ_KEEPS_INC: assert property (@(posedge clk) disable iff (rst)
            (rd_g && fire_w[g]) |=> (cnt_all[g] == CNT_W'(1))); // R6
        AST_COUNT_WRAPS: assert property (@(posedge clk) disable iff (rst)
            (!rd_g && fire_w[g] && cnt_all[g] == '1) |=> (cnt_all[g] == '0)); // R7
        AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
            (!run_q[g] && !rd_g) |=> ($stable(cnt_all[g]) || run_q[g])); // R8
        AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            $rose(run_q[g]) |-> (cnt_all[g] == '0)); // R9
    end
endmodule

bind tmr_unit tmr_unit_chk i_tmr_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_ce    (cpu_ce),
    .bus_addr  (bus_addr),
    .bus_re    (bus_re),
    .run_q     (run_q),
    .fire_w    (fire_w),
    .cnt_all   (cnt_all),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow)
);

// File: tb/test_tmr_unit.sv
`timescale 1ns/1ps
module test_tmr_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_ce = 1'b1;
    logic       half_ce = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    int         cyc = 0;
    int         n_cmp = 0;
    int         n_bad = 0;

    tmr_unit i_tmr_unit (
        .clk       (clk),
        .rst       (rst),
        .cpu_ce    (cpu_ce),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) cpu_ce <= half_ce ? ~cpu_ce : 1'b1;

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output int v);
        bus_addr = a; bus_re = 1'b1;
        #1 v = int'(bus_rdata);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Poll every cycle until a nonzero count; 'at' is the cycle just after
    // the edge that incremented the counter.
    task automatic sync_fire(logic [7:0] a, output int at, output int val);
        int v = 0;
        at = 0;
        while (v == 0) begin
            at = cyc;
            bus_read(a, v);
        end
        val = v;
    endtask

    task automatic t_reset_and_map();
        int v;
        for (int i = 0; i < 3; i++) begin
            bus_read(8'hFD + 8'(i), v);
            check("R1 counter after reset", v, 0);
        end
        repeat (400) @(negedge clk);
        bus_read(8'hFF, v);
        check("R1 no count while disabled", v, 0);
        bus_write(8'hFA, 8'h55);
        bus_read(8'hFA, v);
        check("R10 divisor read back is zero", v, 0);
        bus_write(8'hF1, 8'h00);
        bus_read(8'hF1, v);
        check("R10 control read is zero", v, 0);
        bus_read(8'h20, v);
        check("R10 unmapped read is zero", v, 0);
        bus_write(8'hFA, 8'h00);
    endtask

    task automatic t_interval(int ch, int d, int expect_cyc, string tag);
        int t1, t2, v1, v2, v;
        bus_write(8'hF1, 8'h00);
        bus_write(8'hFA + 8'(ch), 8'(d));
        for (int i = 0; i < 3; i++) bus_read(8'hFD + 8'(i), v);
        bus_write(8'hF1, 8'(1 << ch));
        sync_fire(8'hFD + 8'(ch), t1, v1);
        sync_fire(8'hFD + 8'(ch), t2, v2);
        check({tag, " first read value"}, v1, 1);
        check({tag, " second read value"}, v2, 1);
        check({tag, " interval"}, t2 - t1, expect_cyc);
        for (int i = 0; i < 3; i++) begin
            if (i != ch) begin
                bus_read(8'hFD + 8'(i), v);
                check("R8 other timer idle", v, 0);
            end
        end
        bus_write(8'hF1, 8'h00);
    endtask

    task automatic t_wrap_and_collide();
        int k, v;
        bus_write(8'hF1, 8'h00);
        bus_write(8'hFC, 8'h00);
        bus_write(8'hF1, 8'h04);
        sync_fire(8'hFF, k, v);
        wait_to(k + 280);
        bus_read(8'hFF, v);
        check("R7 17 unread ticks wrap to 1", v, 1);
        wait_to(k + 303);
        bus_read(8'hFF, v);
        check("R6 colliding read returns old", v, 1);
        bus_read(8'hFF, v);
        check("R6 increment kept after colliding read", v, 1);
        bus_write(8'hF1, 8'h00);
    endtask

    task automatic t_disable(bit reenable);
        int k, v, at;
        bus_write(8'hF1, 8'h00);
        bus_write(8'hFC, 8'h03);
        bus_write(8'hF1, 8'h04);
        sync_fire(8'hFF, k, v);
        wait_to(k + 99);
        bus_write(8'hF1, 8'h00);
        if (!reenable) begin
            wait_to(k + 150);
            bus_read(8'hFF, v);
            check("R8 count held while disabled", v, 1);
        end else begin
            wait_to(k + 159);
            bus_write(8'hF1, 8'h04);
            bus_read(8'hFF, v);
            check("R9 enable clears output", v, 0);
            sync_fire(8'hFF, at, v);
            check("R9 stage restarted, full interval", at - k, 224);
        end
        bus_write(8'hF1, 8'h00);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_map();
        t_interval(2, 0, 16, "R4 d=0");
        t_interval(2, 5, 96, "R4 d=5");
        t_interval(2, 255, 4096, "R4 d=255");
        t_interval(0, 0, 128, "R3 t0 d=0");
        t_interval(1, 2, 384, "R3 t1 d=2");
        t_interval(0, 255, 32768, "R3 t0 d=255");
        t_wrap_and_collide();
        t_disable(1'b0);
        t_disable(1'b1);
        half_ce = 1'b1;
        t_interval(2, 0, 32, "R2 half-rate enable fast");
        t_interval(1, 0, 256, "R2 half-rate enable slow");
        half_ce = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule